// File: doc/BRIEF.md
# Masked Interrupt Latch Group

This block collects up to 32 single-cycle event pulses from one class of interrupt sources. It holds them until software services them, and it raises one combined request toward an upstream aggregator. It has two gates in series. The mask decides whether an arriving pulse is captured at all. The enable decides whether a captured bit takes part in the upstream request. A captured bit stays pending until software writes a one to its position in the identity register.

Software reaches four 32-bit registers through a small byte-addressed port. Reads are combinational. Writes take effect at the next clock edge. A status register shows the event inputs as sampled on the previous edge. The combined request is further limited by a build-time group mask, so several copies of the block can sit under a top-level aggregator with each copy reporting only the bits assigned to it.

Top module: `irq_latch_group`

## Requirements
- R1: After reset the mask register reads all ones; the enable, identity and status registers read zero; `irq_o` is low.
- R2: An event pulse on bit n while mask bit n is 0 sets identity bit n at that clock edge, so the bit reads back as 1 just after the edge.
- R3: An event pulse on bit n while mask bit n is 1 leaves identity unchanged, and clearing the mask bit afterwards does not bring the lost event back.
- R4: A write to the identity register clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R5: A write to the mask register or to the enable register replaces its whole 32-bit value.
- R6: `irq_o` is high in the cycle after identity AND enable AND `GROUP_MASK` is nonzero, and low in the cycle after it is zero. This makes it re-evaluated one cycle after any register write or captured event.
- R7: Identity bits that are enabled but lie outside `GROUP_MASK` never raise `irq_o`.
- R8: When an event sets an identity bit in the same cycle that software writes a 1 to clear it, the bit ends up set.
- R9: The status register reads the raw event inputs sampled at the previous clock edge. Writes to it have no effect.
- R10: Register selection uses byte offsets from the group base: 0x0 status, 0x4 mask, 0x8 identity, 0xC enable. An address with either of its two low bits set reads zero and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | 32 | Event pulses, one per source bit |
| addr_i | input | 4 | Byte offset of the register being accessed |
| wr_en_i | input | 1 | Write strobe for the addressed register |
| wr_data_i | input | 32 | Write data |
| rd_data_o | output | 32 | Combinational read data of the addressed register |
| irq_o | output | 1 | Combined upstream request |

## Verification
Register effects of a write or an event are due at the same edge that samples them. The bench therefore reads the registers back one nanosecond after that edge. The status register shows the inputs of that edge in the same window. `irq_o` follows the register state by one more edge. The bench model computes the request from the state before each edge and compares it after the edge. A single step task drives every stimulus, so each comparison lands in the cycle where its result is due. The bench sweeps each bit position through capture, masking, clearing and collision. It then runs a long pseudo-random mix of events and writes.

// File: rtl/ilg_pkg.sv
package ilg_pkg;

    // Word selector taken from byte offset bits [3:2]
    typedef enum logic [1:0] {
        SEL_STATUS = 2'd0,
        SEL_MASK   = 2'd1,
        SEL_IDENT  = 2'd2,
        SEL_ENABLE = 2'd3
    } ilg_sel_e;

    localparam int unsigned ILG_ADDR_W = 4;

endpackage

// File: rtl/ilg_decode.sv
module ilg_decode
    import ilg_pkg::*;
#(
    parameter int unsigned AW = ILG_ADDR_W
) (
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    output logic          hit_o,
    output ilg_sel_e      sel_o,
    output logic          wr_mask_o,
    output logic          wr_ident_o,
    output logic          wr_enable_o
);

    logic aligned;

    always_comb begin
        aligned     = (addr_i[1:0] == 2'b00);
        sel_o       = ilg_sel_e'(addr_i[3:2]);
        hit_o       = aligned;
        wr_mask_o   = wr_en_i && aligned && (sel_o == SEL_MASK);
        wr_ident_o  = wr_en_i && aligned && (sel_o == SEL_IDENT);
        wr_enable_o = wr_en_i && aligned && (sel_o == SEL_ENABLE);
    end

endmodule

// File: rtl/ilg_latch.sv
module ilg_latch #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] ident_q_i,
    input  logic [W-1:0] evt_i,
    input  logic [W-1:0] mask_q_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] ident_d_o
);

    // Per bit: capture wins over a same-cycle software clear
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic cap;
        always_comb begin
            cap          = evt_i[b] & ~mask_q_i[b];
            ident_d_o[b] = cap | (ident_q_i[b] & ~clr_i[b]);
        end
    end

endmodule

// File: rtl/ilg_summary.sv
module ilg_summary #(
    parameter int unsigned W          = 32,
    parameter logic [W-1:0] GROUP_MASK = '1
) (
    input  logic [W-1:0] ident_q_i,
    input  logic [W-1:0] enable_q_i,
    output logic [W-1:0] upstream_o,
    output logic         req_o
);

    always_comb begin
        upstream_o = ident_q_i & enable_q_i;
        req_o      = |(upstream_o & GROUP_MASK);
    end

endmodule

// File: rtl/irq_latch_group.sv
module irq_latch_group
    import ilg_pkg::*;
#(
    parameter int unsigned  W          = 32,
    parameter int unsigned  AW         = ILG_ADDR_W,
    parameter logic [W-1:0] GROUP_MASK = '1
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [W-1:0]  evt_i,
    input  logic [AW-1:0] addr_i,
    input  logic          wr_en_i,
    input  logic [W-1:0]  wr_data_i,
    output logic [W-1:0]  rd_data_o,
    output logic          irq_o
);

    typedef struct packed {
        logic [W-1:0] status;
        logic [W-1:0] mask;
        logic [W-1:0] ident;
        logic [W-1:0] enable;
        logic         req;
    } state_t;

    state_t st_d, st_q;

    logic         hit;
    ilg_sel_e     sel;
    logic         wr_mask, wr_ident, wr_enable;
    logic [W-1:0] clr_vec;
    logic [W-1:0] ident_next;
    logic [W-1:0] upstream;
    logic         req_now;

    ilg_decode #(.AW(AW)) u_dec (
        .addr_i      (addr_i),
        .wr_en_i     (wr_en_i),
        .hit_o       (hit),
        .sel_o       (sel),
        .wr_mask_o   (wr_mask),
        .wr_ident_o  (wr_ident),
        .wr_enable_o (wr_enable)
    );

    assign clr_vec = wr_ident ? wr_data_i : '0;

    ilg_latch #(.W(W)) u_latch (
        .ident_q_i (st_q.ident),
        .evt_i     (evt_i),
        .mask_q_i  (st_q.mask),
        .clr_i     (clr_vec),
        .ident_d_o (ident_next)
    );

    ilg_summary #(.W(W), .GROUP_MASK(GROUP_MASK)) u_sum (
        .ident_q_i  (st_q.ident),
        .enable_q_i (st_q.enable),
        .upstream_o (upstream),
        .req_o      (req_now)
    );

    always_comb begin
        st_d        = st_q;
        st_d.status = evt_i;
        st_d.ident  = ident_next;
        st_d.req    = req_now;
        if (wr_mask) begin
            st_d.mask = wr_data_i;
        end
        if (wr_enable) begin
            st_d.enable = wr_data_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.status <= '0;
            st_q.mask   <= '1;
            st_q.ident  <= '0;
            st_q.enable <= '0;
            st_q.req    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rd_data_o = '0;
        if (hit) begin
            unique case (sel)
                SEL_STATUS: rd_data_o = st_q.status;
                SEL_MASK:   rd_data_o = st_q.mask;
                SEL_IDENT:  rd_data_o = st_q.ident;
                SEL_ENABLE: rd_data_o = st_q.enable;
                default:    rd_data_o = '0;
            endcase
        end
    end

    assign irq_o = st_q.req;

    // upstream is kept visible for cascading and debug probing
    logic unused_upstream;
    assign unused_upstream = ^upstream;

endmodule

// File: rtl/irq_latch_group_chk.sv
module irq_latch_group_chk #(
    parameter int unsigned  W          = 32,
    parameter logic [W-1:0] GROUP_MASK = '1
) (
    input logic         clk_i,
    input logic         rst_ni,
    input logic [W-1:0] evt_i,
    input logic [3:0]   addr_i,
    input logic         wr_en_i,
    input logic [W-1:0] wr_data_i,
    input logic [W-1:0] status_q,
    input logic [W-1:0] mask_q,
    input logic [W-1:0] ident_q,
    input logic [W-1:0] enable_q,
    input logic         irq_o
);

    logic [W-1:0] cap_vec;
    logic [W-1:0] clr_vec;
    assign cap_vec = evt_i & ~mask_q;
    assign clr_vec = (wr_en_i && addr_i == 4'h8) ? wr_data_i : '0;

    // R2, R8: unmasked events are present after the edge
    a_r2_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|cap_vec) |=> ((ident_q & $past(cap_vec)) == $past(cap_vec)));

    // R3: identity gains bits only from unmasked events
    a_r3_no_masked_gain: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((ident_q & ~$past(ident_q) & ~$past(cap_vec)) == '0));

    // R4: identity loses bits only through a write of one
    a_r4_w1c_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (($past(ident_q) & ~ident_q & ~$past(clr_vec)) == '0));

    // R5: mask write replaces the value
    a_r5_mask_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && addr_i == 4'h4) |=> (mask_q == $past(wr_data_i)));

    // R6, R7: request follows the gated identity one cycle later
    a_r6_request: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (irq_o == $past(|(ident_q & enable_q & GROUP_MASK))));

    // R9: status mirrors the previous inputs
    a_r9_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (status_q == $past(evt_i)));

endmodule

bind irq_latch_group irq_latch_group_chk #(.W(W), .GROUP_MASK(GROUP_MASK)) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .evt_i     (evt_i),
    .addr_i    (addr_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .status_q  (st_q.status),
    .mask_q    (st_q.mask),
    .ident_q   (st_q.ident),
    .enable_q  (st_q.enable),
    .irq_o     (irq_o)
);

// File: tb/sim_irq_latch_group.sv
`timescale 1ns/100ps
module sim_irq_latch_group;

    localparam logic [31:0] GM = 32'h0F0F_FFF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] evt = '0;
    logic [3:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rd_data;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;
    bit done = 0;

    logic [31:0] m_st, m_mask, m_id, m_en;
    logic        m_irq;

    irq_latch_group #(.W(32), .AW(4), .GROUP_MASK(GM)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .addr_i(addr),
        .wr_en_i(wr_en), .wr_data_i(wdata), .rd_data_o(rd_data), .irq_o(irq)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000 && !done) begin
            done = 1;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        addr = a;
        #0.2;
        v = rd_data;
    endtask

    task automatic cyc(input logic [31:0] ev, input logic we,
                       input logic [3:0] a, input logic [31:0] wd);
        logic [31:0] clr;
        logic        nirq;
        evt = ev; wr_en = we; addr = a; wdata = wd;
        @(posedge clk);
        clr   = (we && a == 4'h8) ? wd : '0;
        nirq  = |(m_id & m_en & GM);
        m_id  = (m_id & ~clr) | (ev & ~m_mask);
        if (we && a == 4'h4) m_mask = wd;
        if (we && a == 4'hC) m_en = wd;
        m_st  = ev;
        m_irq = nirq;
        #1;
        evt = '0; wr_en = 1'b0;
    endtask

    task automatic check_all(input string tag);
        logic [31:0] v;
        rd(4'h0, v); chk({tag, " R9 status"}, v, m_st);
        rd(4'h4, v); chk({tag, " R5 mask"}, v, m_mask);
        rd(4'h8, v); chk({tag, " R2 ident"}, v, m_id);
        rd(4'hC, v); chk({tag, " R10 enable"}, v, m_en);
        chk({tag, " R6 irq"}, {31'b0, irq}, {31'b0, m_irq});
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] lfsr;
        m_st = '0; m_mask = '1; m_id = '0; m_en = '0; m_irq = 1'b0;
        #5 rst_n = 1'b1;
        @(posedge clk); #1;

        // R1 reset values
        rd(4'h0, v); chk("R1 status", v, 32'h0);
        rd(4'h4, v); chk("R1 mask", v, 32'hFFFF_FFFF);
        rd(4'h8, v); chk("R1 ident", v, 32'h0);
        rd(4'hC, v); chk("R1 enable", v, 32'h0);
        chk("R1 irq", {31'b0, irq}, 32'h0);

        // R5 / R10 full replacement
        cyc('0, 1, 4'h4, 32'hA5A5_5A5A); check_all("R5a");
        cyc('0, 1, 4'hC, 32'h1234_5678); check_all("R5b");
        cyc('0, 1, 4'h4, 32'h0);         check_all("R5c");
        cyc('0, 1, 4'hC, 32'hFFFF_FFFF); check_all("R5d");
        // R10 misaligned access ignored, reads zero
        cyc('0, 1, 4'h5, 32'hDEAD_BEEF); check_all("R10 misaligned write");
        rd(4'h6, v); chk("R10 misaligned read", v, 32'h0);
        // R9 write to status ignored
        cyc('0, 1, 4'h0, 32'hFFFF_FFFF); check_all("R9 status write");

        // R2 R4 R6 R7 per bit sweep
        for (int n = 0; n < 32; n++) begin
            cyc(32'h1 << n, 0, 4'h0, '0); check_all("R2 sweep set");
            cyc('0, 0, 4'h0, '0);          check_all("R6 R7 sweep irq");
            chk("R7 irq vs group mask", {31'b0, irq}, {31'b0, GM[n]});
            cyc('0, 1, 4'h8, ~(32'h1 << n)); check_all("R4 write zeros keep");
            cyc('0, 1, 4'h8, 32'h1 << n);    check_all("R4 clear");
            cyc('0, 0, 4'h0, '0);            check_all("R6 irq drop");
        end

        // R3 masked events lost
        cyc('0, 1, 4'h4, 32'hFFFF_FFFF);
        cyc(32'hFFFF_FFFF, 0, 4'h0, '0); check_all("R3 masked");
        cyc('0, 1, 4'h4, 32'h0);         check_all("R3 unmask");
        rd(4'h8, v); chk("R3 ident stays", v, 32'h0);

        // R8 set beats clear
        cyc(32'h0000_0F00, 0, 4'h0, '0);
        cyc(32'h0000_0300, 1, 4'h8, 32'h0000_0F00); check_all("R8 collision");
        rd(4'h8, v); chk("R8 ident", v, 32'h0000_0300);
        cyc('0, 1, 4'h8, 32'hFFFF_FFFF); check_all("R4 clear all");

        // mixed pseudo-random traffic
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 600; i++) begin
            logic [31:0] e, d;
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            e = lfsr & {lfsr[15:0], lfsr[31:16]};
            d = {lfsr[7:0], lfsr[31:8]};
            cyc(e, lfsr[3], {lfsr[5:4], 2'b00}, d);
            check_all("R2 R4 R5 R6 R9 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule